// File: doc/BRIEF.md
# DDR2 Controller Configuration Register Block

This block is the software-visible register file of a DDR2 memory controller. It sits on a plain 32-bit peripheral bus made of a byte address, a write enable, write data, a one-cycle access strobe and registered read data. Behind that bus it keeps a memory configuration word, a status/command word, and a bank of general storage words that hold timing and ECC settings for the rest of the controller.

Software brings the memory up by writing the status word with its start bit set. The block treats that command as finishing in the same cycle. It clears the start bit, latches a sticky init-done flag and raises `mem_en`, which tells the fabric to map the DRAM window in. A fixed revision word can be read at the end of the map. Any access to an offset outside the map, or to a byte address that is not word-aligned, is answered with zero and raises a one-cycle `err` pulse. The DRAM command sequencing, PHY and timing generation are not part of this block.

Top module: `ddrc_regblk`

## Requirements
- R1: A write to the configuration word (byte offset 0x00) keeps only `wdata[15:0]`, and bits 31:16 of that word always read as zero.
- R2: A write to the status word (byte offset 0x04) changes only bits 5:0. Bit 8 (init-done) keeps its value whatever the written data, and all other bits read as zero.
- R3: While init-done is clear, a status write with bit 0 (start) set stores bit 0 as 0, sets init-done, and drives `mem_en` high from the next clock edge onward.
- R4: While init-done is set, a status write with bit 0 set stores bit 0 as written (it reads back as 1) and leaves init-done and `mem_en` unchanged.
- R5: Byte offsets 0x08 through 0x4C are eighteen independent 32-bit read/write storage words.
- R6: Byte offset 0x50 is read-only and returns 0x00000100. A write there changes nothing and is flagged as an error.
- R7: Reads of undefined offsets (above 0x50, or a byte address with bits 1:0 not zero) return zero, and writes to them change no register.
- R8: `err` is high for exactly the one cycle after a strobed access to an undefined offset or a write to the revision word, and is low otherwise.
- R9: `rdata` is registered. It takes the read value on the clock edge that samples a read strobe and holds that value through idle cycles and write cycles.
- R10: Synchronous reset clears every register and `rdata`. `mem_en`, which status bit 8 always mirrors, is cleared unless `boot_bypass` is high during reset, in which case it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boot_bypass | input | 1 | Keeps `mem_en` through reset when high |
| stb | input | 1 | Access strobe, one access per cycle it is high |
| we | input | 1 | Write (1) or read (0) for the strobed access |
| addr | input | 12 | Byte address inside the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse for an undefined access |
| mem_en | output | 1 | DRAM window enabled (init done) |

## Verification
The assertions assume that `stb` and `we` are always known. They also assume the bus presents at most one access per cycle and holds no access across a reset cycle. The address may be any 12-bit value, including misaligned ones. The bench drives every input on the falling clock edge and lowers `stb` on the cycle after each access. It applies reset only between accesses, with `boot_bypass` chosen at random. The random address mix favours the defined words but also reaches offsets above the map and misaligned addresses, so the undefined-offset properties are exercised.

// File: rtl/ddrc_reg_pkg.sv
package ddrc_reg_pkg;
  // which register family a bus address lands in
  typedef enum logic [2:0] {
    SEL_CFG   = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_STORE = 3'd2,
    SEL_REV   = 3'd3,
    SEL_NONE  = 3'd4
  } reg_sel_e;

  // word positions fixed by the map; storage follows the status word
  localparam int unsigned CFG_WORD   = 0;
  localparam int unsigned STAT_WORD  = 1;
  localparam int unsigned STORE_BASE = 2;
endpackage

// File: rtl/ddrc_addr_decode.sv
module ddrc_addr_decode
  import ddrc_reg_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned NUM_STORE = 18,
  parameter int unsigned IDXW      = $clog2(NUM_STORE)
) (
  input  logic [AW-1:0]   addr,
  output reg_sel_e        sel,
  output logic [IDXW-1:0] store_idx
);
  localparam int unsigned WW       = AW - 2;
  localparam int unsigned REV_WORD = STORE_BASE + NUM_STORE;

  logic [WW-1:0] word;
  logic          aligned;
  logic [WW-1:0] rel;

  assign word    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign rel     = word - WW'(STORE_BASE);
  assign store_idx = rel[IDXW-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (word == WW'(CFG_WORD))                                   sel = SEL_CFG;
      else if (word == WW'(STAT_WORD))                             sel = SEL_STAT;
      else if (word >= WW'(STORE_BASE) && word < WW'(REV_WORD))    sel = SEL_STORE;
      else if (word == WW'(REV_WORD))                              sel = SEL_REV;
    end
  end
endmodule

// File: rtl/ddrc_store_bank.sv
module ddrc_store_bank #(
  parameter int unsigned DW        = 32,
  parameter int unsigned NUM_STORE = 18,
  parameter int unsigned IDXW      = $clog2(NUM_STORE)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_word
);
  logic [NUM_STORE-1:0][DW-1:0] bank_q;

  for (genvar i = 0; i < NUM_STORE; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                    bank_q[i] <= '0;
      else if (wr_en && idx == IDXW'(i))          bank_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_STORE; i++)
      if (idx == IDXW'(i)) rd_word = bank_q[i];
  end
endmodule

// File: rtl/ddrc_init_ctrl.sv
module ddrc_init_ctrl #(
  parameter int unsigned DW        = 32,
  parameter int unsigned CFG_BITS  = 16,
  parameter int unsigned STAT_BITS = 6,
  parameter int unsigned DONE_BIT  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_bypass,
  input  logic          cfg_we,
  input  logic          stat_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_word,
  output logic [DW-1:0] stat_word,
  output logic          mem_en
);
  localparam logic [STAT_BITS-1:0] START_MASK = STAT_BITS'(1);

  logic [CFG_BITS-1:0]  cfg_q;
  logic [STAT_BITS-1:0] stat_q;
  logic                 done_q;
  logic                 fire;

  assign fire = stat_we && !done_q && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      stat_q <= '0;
      done_q <= done_q & boot_bypass;
    end else begin
      if (cfg_we) cfg_q <= wdata[CFG_BITS-1:0];
      if (stat_we) begin
        if (fire) stat_q <= wdata[STAT_BITS-1:0] & ~START_MASK;
        else      stat_q <= wdata[STAT_BITS-1:0];
      end
      if (fire) done_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_word                   = '0;
    cfg_word[CFG_BITS-1:0]     = cfg_q;
    stat_word                  = '0;
    stat_word[STAT_BITS-1:0]   = stat_q;
    stat_word[DONE_BIT]        = done_q;
  end

  assign mem_en = done_q;
endmodule

// File: rtl/ddrc_regblk.sv
module ddrc_regblk
  import ddrc_reg_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned DW        = 32,
  parameter int unsigned NUM_STORE = 18,
  parameter int unsigned CFG_BITS  = 16,
  parameter int unsigned STAT_BITS = 6,
  parameter int unsigned DONE_BIT  = 8,
  parameter logic [31:0] REV_VALUE = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_bypass,
  input  logic          stb,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          mem_en
);
  localparam int unsigned IDXW = $clog2(NUM_STORE);

  reg_sel_e        sel;
  logic [IDXW-1:0] store_idx;
  logic [DW-1:0]   cfg_word, stat_word, store_word;
  logic [DW-1:0]   rd_mux;
  logic            bad_acc;
  logic [DW-1:0]   rdata_q;
  logic            err_q;

  ddrc_addr_decode #(.AW(AW), .NUM_STORE(NUM_STORE), .IDXW(IDXW)) u_dec (
    .addr      (addr),
    .sel       (sel),
    .store_idx (store_idx)
  );

  ddrc_init_ctrl #(
    .DW(DW), .CFG_BITS(CFG_BITS), .STAT_BITS(STAT_BITS), .DONE_BIT(DONE_BIT)
  ) u_init (
    .clk         (clk),
    .rst         (rst),
    .boot_bypass (boot_bypass),
    .cfg_we      (stb && we && sel == SEL_CFG),
    .stat_we     (stb && we && sel == SEL_STAT),
    .wdata       (wdata),
    .cfg_word    (cfg_word),
    .stat_word   (stat_word),
    .mem_en      (mem_en)
  );

  ddrc_store_bank #(.DW(DW), .NUM_STORE(NUM_STORE), .IDXW(IDXW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (stb && we && sel == SEL_STORE),
    .idx     (store_idx),
    .wdata   (wdata),
    .rd_word (store_word)
  );

  always_comb begin
    unique case (sel)
      SEL_CFG:   rd_mux = cfg_word;
      SEL_STAT:  rd_mux = stat_word;
      SEL_STORE: rd_mux = store_word;
      SEL_REV:   rd_mux = DW'(REV_VALUE);
      default:   rd_mux = '0;
    endcase
  end

  assign bad_acc = (sel == SEL_NONE) || (we && sel == SEL_REV);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= stb && bad_acc;
      if (stb && !we) rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/ddrc_regblk_chk.sv
module ddrc_regblk_chk #(
  parameter int unsigned AW        = 12,
  parameter int unsigned DW        = 32,
  parameter int unsigned NUM_STORE = 18,
  parameter logic [31:0] REV_VALUE = 32'h0000_0100
) (
  input logic          clk,
  input logic          rst,
  input logic          boot_bypass,
  input logic          stb,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          err,
  input logic          mem_en
);
  localparam logic [AW-1:0] CFG_ADDR  = '0;
  localparam logic [AW-1:0] STAT_ADDR = AW'(4);
  localparam logic [AW-1:0] REV_ADDR  = AW'(4 * (2 + NUM_STORE));

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stb && !we && addr == CFG_ADDR) |=> (rdata[DW-1:16] == '0)); // R1

  AST_START_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (stb && we && addr == STAT_ADDR && wdata[0]) |=> mem_en); // R3

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> mem_en); // R4

  AST_REV_CONST: assert property (@(posedge clk) disable iff (rst)
    (stb && !we && addr == REV_ADDR) |=> (rdata == DW'(REV_VALUE))); // R6

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stb && !we && addr > REV_ADDR) |=> (rdata == '0)); // R7

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !stb |=> !err); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!stb || we) |=> $stable(rdata)); // R9

  AST_RESET_DROPS_EN: assert property (@(posedge clk)
    (rst && !boot_bypass) |=> !mem_en); // R10

  AST_BYPASS_KEEPS_EN: assert property (@(posedge clk)
    (rst && boot_bypass && mem_en) |=> mem_en); // R10
endmodule

bind ddrc_regblk ddrc_regblk_chk #(
  .AW(AW), .DW(DW), .NUM_STORE(NUM_STORE), .REV_VALUE(REV_VALUE)
) u_chk (
  .clk(clk), .rst(rst), .boot_bypass(boot_bypass), .stb(stb), .we(we),
  .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .mem_en(mem_en)
);

// File: tb/tb_ddrc_regblk.sv
module tb_ddrc_regblk;
  logic        clk = 1'b0;
  logic        rst, boot_bypass, stb, we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err, mem_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_cfg;
  logic [5:0]  m_stat;
  logic        m_en;
  logic [31:0] m_store [18];
  logic [31:0] m_rdata;

  always #4 clk = ~clk; // 125 MHz

  ddrc_regblk dut (
    .clk(clk), .rst(rst), .boot_bypass(boot_bypass), .stb(stb), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .mem_en(mem_en)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w;
    if (a[1:0] != 2'b00) return 32'h0;
    w = int'(a[11:2]);
    if (w == 0) return {16'h0, m_cfg};
    if (w == 1) return {23'h0, m_en, 2'b00, m_stat};
    if (w >= 2 && w <= 19) return m_store[w-2];
    if (w == 20) return 32'h0000_0100;
    return 32'h0;
  endfunction

  function automatic bit exp_err(input logic [11:0] a, input bit wr);
    int w;
    if (a[1:0] != 2'b00) return 1'b1;
    w = int'(a[11:2]);
    return (w > 20) || (w == 20 && wr);
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    int w;
    if (a[1:0] != 2'b00) return;
    w = int'(a[11:2]);
    if (w == 0) m_cfg = d[15:0];
    else if (w == 1) begin
      if (!m_en && d[0]) begin
        m_stat = d[5:0] & 6'h3E;
        m_en   = 1'b1;
      end else m_stat = d[5:0];
    end else if (w >= 2 && w <= 19) m_store[w-2] = d;
  endfunction

  task automatic do_reset(input bit bp);
    @(negedge clk);
    rst = 1'b1; boot_bypass = bp; stb = 1'b0;
    @(negedge clk);
    rst = 1'b0; boot_bypass = 1'b0;
    m_cfg = '0; m_stat = '0; m_en = m_en & bp; m_rdata = '0;
    for (int i = 0; i < 18; i++) m_store[i] = '0;
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [31:0] exp_d;
    bit exp_e;
    @(negedge clk);
    stb = 1'b1; we = wr; addr = a; wdata = d;
    exp_e = exp_err(a, wr);
    if (!wr) m_rdata = exp_read(a);
    else model_write(a, d);
    exp_d = m_rdata;
    @(negedge clk);
    stb = 1'b0; we = 1'b0;
    check(rdata == exp_d, {tag, " rdata"}, rdata, exp_d);
    check(err == exp_e, {tag, " err R8"}, {31'h0, err}, {31'h0, exp_e});
    check(mem_en == m_en, {tag, " mem_en"}, {31'h0, mem_en}, {31'h0, m_en});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E_3D4C));
    rst = 1'b1; boot_bypass = 1'b0; stb = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    m_en = 1'b0;
    repeat (2) @(negedge clk);
    do_reset(1'b0);

    // R10 reset state
    check(mem_en == 1'b0, "R10 mem_en after reset", {31'h0, mem_en}, 32'h0);
    check(rdata == 32'h0, "R10 rdata after reset", rdata, 32'h0);
    access(1'b0, 12'h004, 32'h0, "R10 status reset");
    access(1'b0, 12'h020, 32'h0, "R10 store reset");

    // R1 configuration masking
    access(1'b1, 12'h000, 32'hDEAD_BEEF, "R1 cfg write");
    access(1'b0, 12'h000, 32'h0, "R1 cfg read");
    check(rdata == 32'h0000_BEEF, "R1 cfg value", rdata, 32'h0000_BEEF);

    // R2 status field mask, no start
    access(1'b1, 12'h004, 32'hFFFF_FEFE, "R2 status write");
    access(1'b0, 12'h004, 32'h0, "R2 status read");
    check(rdata == 32'h0000_003E, "R2 status value", rdata, 32'h0000_003E);

    // R3 start command
    access(1'b1, 12'h004, 32'h0000_0021, "R3 start write");
    check(mem_en == 1'b1, "R3 mem_en raised", {31'h0, mem_en}, 32'h1);
    access(1'b0, 12'h004, 32'h0, "R3 status read");
    check(rdata == 32'h0000_0120, "R3 status value", rdata, 32'h0000_0120);

    // R2 bit 8 unaffected by written zero
    access(1'b1, 12'h004, 32'h0, "R2 clear attempt");
    access(1'b0, 12'h004, 32'h0, "R2 done kept");

    // R4 no retrigger, bit 0 kept
    access(1'b1, 12'h004, 32'h0000_0001, "R4 second start");
    access(1'b0, 12'h004, 32'h0, "R4 status read");
    check(rdata == 32'h0000_0101, "R4 status value", rdata, 32'h0000_0101);

    // R5 storage bank ends
    access(1'b1, 12'h008, 32'hA5A5_0001, "R5 first store");
    access(1'b1, 12'h04C, 32'h5A5A_FFFE, "R5 last store");
    access(1'b0, 12'h008, 32'h0, "R5 first read");
    access(1'b0, 12'h04C, 32'h0, "R5 last read");

    // R6 revision and write attempt
    access(1'b1, 12'h050, 32'hFFFF_FFFF, "R6 rev write");
    access(1'b0, 12'h050, 32'h0, "R6 rev read");

    // R7 undefined and misaligned
    access(1'b1, 12'h054, 32'h1234_5678, "R7 write above map");
    access(1'b1, 12'h009, 32'h1234_5678, "R7 misaligned write");
    access(1'b0, 12'h008, 32'h0, "R7 store untouched");
    access(1'b0, 12'hFFC, 32'h0, "R7 top read");
    access(1'b0, 12'h002, 32'h0, "R7 misaligned read");

    // R9 hold across idle and writes
    access(1'b0, 12'h04C, 32'h0, "R9 load");
    repeat (3) @(negedge clk);
    check(rdata == m_rdata, "R9 idle hold", rdata, m_rdata);
    access(1'b1, 12'h000, 32'h0000_1111, "R9 write hold");

    // R10 reset with bypass keeps enable
    do_reset(1'b1);
    check(mem_en == 1'b1, "R10 bypass keeps mem_en", {31'h0, mem_en}, 32'h1);
    access(1'b0, 12'h004, 32'h0, "R10 status after bypass");
    access(1'b0, 12'h000, 32'h0, "R10 cfg cleared");
    do_reset(1'b0);
    check(mem_en == 1'b0, "R10 plain reset drops mem_en", {31'h0, mem_en}, 32'h0);

    // random mix
    for (int k = 0; k < 1500; k++) begin
      int unsigned r;
      logic [11:0] a;
      string tg;
      r = $urandom % 100;
      if (r < 2) begin
        do_reset(1'($urandom % 2));
        continue;
      end
      if (r < 10) a = 12'(($urandom % 24) * 4 + 1 + ($urandom % 3));
      else if (r < 15) a = 12'($urandom % 4096);
      else a = 12'(($urandom % 22) * 4);
      if (a[1:0] != 0 || a > 12'h050) tg = "R7 random";
      else if (a == 12'h000) tg = "R1 random";
      else if (a == 12'h004) tg = "R3 random";
      else if (a == 12'h050) tg = "R6 random";
      else tg = "R5 random";
      access(1'($urandom % 2), a, $urandom, tg);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule